// File: doc/BRIEF.md
# Multi-Key Combination Reset Detector

This block watches four key inputs and raises a system reset request when a chosen group of those keys has been held high together for long enough. The group is chosen by a two-bit setting. It can be disabled, or it can be keys 0 and 1, keys 0 to 2, or all four keys. A second setting picks the hold time needed before the reset fires. The short hold is about 6 ms. The long hold is 2 seconds.

The block runs from a 32768 Hz clock. In short mode the reset fires after 197 consecutive cycles, which is about 6.01 ms. In long mode it fires after 65536 consecutive cycles, which is 2 s and lies inside the allowed window of 1 to 3 s. Once the request is raised, it stays high for as long as the keys are held. It drops on the first clock after the combination breaks. Its only output is the reset request, which a chip-level reset controller consumes.

Top module: `mkr_top`

## Requirements
- R1: While `rst_n` is low, and after it is released, `sys_reset_o` is 0 until a combination qualifies.
- R2: With `combo_sel_i` = 0 (disabled), no key pattern held for any length of time asserts `sys_reset_o`.
- R3: The condition is met only when every selected key is high in the same cycle. `combo_sel_i` = 1 selects keys 0 and 1, 2 selects keys 0 to 2, and 3 selects keys 0 to 3. A key index k maps to `key_i[k]`.
- R4: With `long_hold_i` = 0, `sys_reset_o` goes high on the 197th consecutive rising edge at which the condition is met. It is still low after the 196th edge.
- R5: With `long_hold_i` = 1, `sys_reset_o` goes high on the 65536th consecutive rising edge at which the condition is met. It is still low after 197 edges and after 65535 edges.
- R6: If any selected key is low at a rising edge, the hold count restarts. A new hold then needs the full threshold counted from its own start.
- R7: `sys_reset_o` stays high for as long as the condition persists after the threshold. It goes low at the first rising edge at which the condition is not met.
- R8: Keys outside the selected group have no effect, whether they are low, high or toggling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32768 Hz timing clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| key_i | input | 4 | Key levels, 1 = pressed/high |
| combo_sel_i | input | 2 | Key group: 0 none, 1 keys 0-1, 2 keys 0-2, 3 keys 0-3 |
| long_hold_i | input | 1 | 1 = 2 s hold (65536 cycles), 0 = short hold (197 cycles) |
| sys_reset_o | output | 1 | Registered reset request |

## Verification
The bench probes the threshold edges, checking 196 against 197 cycles and 65535 against 65536 cycles. A counter that is off by one, or that compares with the wrong limit, would fire a cycle early or late. A hold that is broken and then started again must take a full threshold counted from its own start, so a design that does not clear the count would fire early. The bench also toggles keys outside the selected group during a hold and holds all four keys in disabled mode. A wrong mask would either break the count or reset the system when it should not. Finally, the bench checks that the request drops exactly one edge after the condition breaks. A design that latched the request, or held it for an extra cycle, would fail that check.

// File: rtl/mkr_pkg.sv
package mkr_pkg;

    typedef enum logic {
        HOLD_SHORT = 1'b0,
        HOLD_LONG  = 1'b1
    } hold_mode_e;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/mkr_combo_match.sv
module mkr_combo_match #(
    parameter int NUM_KEYS = 4,
    localparam int SEL_W = $clog2(NUM_KEYS)
) (
    input  logic [NUM_KEYS-1:0] key_i,
    input  logic [SEL_W-1:0]    combo_sel_i,
    output logic [NUM_KEYS-1:0] mask_o,
    output logic                cond_o
);

    logic [NUM_KEYS-1:0] ok;

    // key k takes part when the group is enabled and k <= selection code
    for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
        always_comb begin
            mask_o[k] = (combo_sel_i != '0) && (k <= int'(combo_sel_i));
            ok[k]     = key_i[k] | ~mask_o[k];
        end
    end

    always_comb begin
        cond_o = (combo_sel_i != '0) && (&ok);
    end

endmodule

// File: rtl/mkr_hold_timer.sv
module mkr_hold_timer
    import mkr_pkg::*;
#(
    parameter int unsigned SHORT_CYCLES = 197,
    parameter int unsigned LONG_CYCLES  = 65536,
    localparam int unsigned MAX_CYCLES  = max_u(SHORT_CYCLES, LONG_CYCLES),
    localparam int unsigned CNT_W       = $clog2(MAX_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cond_i,
    input  logic long_i,
    output logic hit_o
);

    localparam logic [CNT_W-1:0] SAT      = CNT_W'(MAX_CYCLES - 1);
    localparam logic [CNT_W-1:0] SHORT_M1 = CNT_W'(SHORT_CYCLES - 1);
    localparam logic [CNT_W-1:0] LONG_M1  = CNT_W'(LONG_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } timer_state_t;

    timer_state_t st_d, st_q;
    logic [CNT_W-1:0] limit;
    hold_mode_e mode;

    always_comb begin
        mode  = hold_mode_e'(long_i);
        limit = (mode == HOLD_LONG) ? LONG_M1 : SHORT_M1;
        st_d  = st_q;
        if (!cond_i) begin
            st_d.cnt = '0;
        end else if (st_q.cnt < SAT) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        // cnt holds the number of earlier consecutive qualifying edges
        hit_o = cond_i && (st_q.cnt >= limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_CLEAR_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !cond_i |=> (st_q.cnt == '0)); // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i && st_q.cnt == SAT) |=> (st_q.cnt == SAT)); // R5

endmodule

// File: rtl/mkr_reset_gen.sv
module mkr_reset_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    output logic req_o
);

    typedef struct packed {
        logic req;
    } gen_state_t;

    gen_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.req = hit_i;
        req_o    = st_q.req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/mkr_top.sv
module mkr_top #(
    parameter int NUM_KEYS              = 4,
    parameter int unsigned SHORT_CYCLES = 197,
    parameter int unsigned LONG_CYCLES  = 65536,
    localparam int SEL_W                = $clog2(NUM_KEYS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_KEYS-1:0] key_i,
    input  logic [SEL_W-1:0]    combo_sel_i,
    input  logic                long_hold_i,
    output logic                sys_reset_o
);

    logic [NUM_KEYS-1:0] mask;
    logic cond;
    logic hit;

    mkr_combo_match #(.NUM_KEYS(NUM_KEYS)) u_match (
        .key_i       (key_i),
        .combo_sel_i (combo_sel_i),
        .mask_o      (mask),
        .cond_o      (cond)
    );

    mkr_hold_timer #(
        .SHORT_CYCLES (SHORT_CYCLES),
        .LONG_CYCLES  (LONG_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .cond_i (cond),
        .long_i (long_hold_i),
        .hit_o  (hit)
    );

    mkr_reset_gen u_gen (
        .clk   (clk),
        .rst_n (rst_n),
        .hit_i (hit),
        .req_o (sys_reset_o)
    );

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (combo_sel_i == '0) |=> !sys_reset_o); // R2

    AST_RISE_NEEDS_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_reset_o) |-> $past((key_i & mask) == mask && mask != '0)); // R3

    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !cond |=> !sys_reset_o); // R7

    AST_PERSIST: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_reset_o && cond) |=> sys_reset_o); // R7

    AST_MASK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (combo_sel_i != '0) |-> (mask[1:0] == 2'b11)); // R8

endmodule

// File: tb/tb_mkr_top.sv
module tb_mkr_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] key_i = '0;
    logic [1:0] combo_sel_i = '0;
    logic       long_hold_i = 1'b0;
    logic       sys_reset_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    mkr_top dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .key_i       (key_i),
        .combo_sel_i (combo_sel_i),
        .long_hold_i (long_hold_i),
        .sys_reset_o (sys_reset_o)
    );

    // {keys[31:28], combo[27:26], long[25], hold cycles[24:8], expected[0]}
    localparam int NV = 10;
    localparam logic [31:0] VEC [NV] = '{
        {4'hF, 2'd0, 1'b0, 17'd300, 8'd0},
        {4'h3, 2'd1, 1'b0, 17'd196, 8'd0},
        {4'h3, 2'd1, 1'b0, 17'd197, 8'd1},
        {4'h1, 2'd1, 1'b0, 17'd300, 8'd0},
        {4'h7, 2'd2, 1'b0, 17'd197, 8'd1},
        {4'h3, 2'd2, 1'b0, 17'd300, 8'd0},
        {4'hF, 2'd3, 1'b0, 17'd197, 8'd1},
        {4'h7, 2'd3, 1'b0, 17'd300, 8'd0},
        {4'hB, 2'd1, 1'b0, 17'd197, 8'd1},
        {4'hC, 2'd1, 1'b0, 17'd300, 8'd0}
    };
    string vec_tag [NV] = '{"R2", "R4", "R4", "R3", "R3", "R3", "R3", "R3", "R8", "R8"};

    task automatic check(input string tag, input logic actual, input logic expected);
        n_tests++;
        if (actual !== expected) begin
            n_fail++;
            $display("FAIL %s: sys_reset_o=%b expected %b at %0t", tag, actual, expected, $time);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_keys();
        key_i = '0;
        wait_cycles(2);
    endtask

    initial begin
        #(200000 * 20);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        key_i = 4'hF;
        combo_sel_i = 2'd3;
        wait_cycles(3);
        check("R1", sys_reset_o, 1'b0);
        key_i = '0;
        @(negedge clk);
        rst_n = 1'b1;
        wait_cycles(2);
        check("R1", sys_reset_o, 1'b0);

        // table walk, then release check
        for (int i = 0; i < NV; i++) begin
            key_i       = '0;
            combo_sel_i = VEC[i][27:26];
            long_hold_i = VEC[i][25];
            wait_cycles(2);
            key_i = VEC[i][31:28];
            wait_cycles(int'(VEC[i][24:8]));
            check(vec_tag[i], sys_reset_o, VEC[i][0]);
            key_i = '0;
            @(negedge clk);
            check("R7", sys_reset_o, 1'b0);
        end

        // R7: persists while held, drops one edge after one selected key falls
        combo_sel_i = 2'd2;
        long_hold_i = 1'b0;
        clear_keys();
        key_i = 4'h7;
        wait_cycles(197 + 500);
        check("R7", sys_reset_o, 1'b1);
        key_i = 4'h5;
        @(negedge clk);
        check("R7", sys_reset_o, 1'b0);

        // R6: broken hold restarts the count
        combo_sel_i = 2'd1;
        clear_keys();
        key_i = 4'h3;
        wait_cycles(150);
        key_i = 4'h1;
        @(negedge clk);
        key_i = 4'h3;
        wait_cycles(196);
        check("R6", sys_reset_o, 1'b0);
        @(negedge clk);
        check("R6", sys_reset_o, 1'b1);

        // R8: unselected keys toggling during the hold
        clear_keys();
        for (int c = 0; c < 196; c++) begin
            key_i = {c[0], ~c[0], 2'b11};
            @(negedge clk);
        end
        check("R8", sys_reset_o, 1'b0);
        key_i = 4'hF;
        @(negedge clk);
        check("R8", sys_reset_o, 1'b1);

        // R2: disabled mode, long hold of all keys
        combo_sel_i = 2'd0;
        clear_keys();
        key_i = 4'hF;
        wait_cycles(2000);
        check("R2", sys_reset_o, 1'b0);

        // R6 in long mode: broken hold does not accumulate
        combo_sel_i = 2'd3;
        long_hold_i = 1'b1;
        clear_keys();
        key_i = 4'hF;
        wait_cycles(1000);
        key_i = 4'hE;
        @(negedge clk);
        key_i = 4'hF;
        wait_cycles(1000);
        check("R6", sys_reset_o, 1'b0);

        // R5: long threshold edges
        clear_keys();
        key_i = 4'hF;
        wait_cycles(197);
        check("R5", sys_reset_o, 1'b0);
        wait_cycles(65535 - 197);
        check("R5", sys_reset_o, 1'b0);
        @(negedge clk);
        check("R5", sys_reset_o, 1'b1);
        key_i = 4'h7;
        @(negedge clk);
        check("R7", sys_reset_o, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule